// File: doc/BRIEF.md
# Intermediate Line Cache Between Two Direct-Mapped Levels

This block is a small set-associative store of whole cache lines that sits between a direct-mapped first-level cache and a direct-mapped second-level cache. Two kinds of line move through it. Lines the first level writes out are always passed on to the second level. Lines the second level returns on a read miss are passed back up. The block keeps a copy of every line that moves in either direction. A first-level conflict miss on a line that was recently evicted or fetched is then served from here, with no trip to the second level.

The block is write-through, so it never holds data that the next level lacks, and a replaced line is simply dropped. Only one upstream request is in service at a time. Upstream `up_ready` stays low from acceptance until the transaction is complete. A flush input, and reset, invalidate the whole store by walking the sets one per cycle.

By default there are 64 sets of 4 ways, with 16-byte lines (4 KiB in total). For a 32-bit physical address, bits [3:0] are the byte offset and are ignored, bits [9:4] select the set, and bits [31:10] form the tag.

Top module: `line_cache_mid`

## Requirements
- R1: After reset is released, or after `flush` is accepted while the block is idle, `up_ready` stays low for exactly SETS cycles (64 by default). Afterwards no previously held line hits, and every round-robin pointer is back at way 0.
- R2: A read that hits raises `up_rvalid` for one cycle, two clock edges after the accepting edge. It carries the most recent data written or filled for that line, and it makes no downstream request.
- R3: A read that misses issues exactly one downstream read whose `dn_addr` has bits [3:0] zero. The returned line appears on `up_rdata` with `up_rvalid` in the cycle after `dn_rvalid`.
- R4: A line filled by a downstream read is allocated, so the next read of that line hits.
- R5: Every upstream write, whether it hits or misses, produces exactly one downstream write carrying the same line data, at the line-aligned address.
- R6: An upstream write allocates the line on a miss and updates it in place on a hit. A later read hits and returns the written data.
- R7: On allocation the lowest-numbered invalid way of the set is used. If all ways are valid, the set's round-robin pointer picks the victim. The pointer advances by one on each allocation into that set and does not move on an in-place update.
- R8: Only one request is outstanding. `up_ready` is low whenever `dn_valid` is high, and in the cycle after any upstream acceptance.
- R9: Once `dn_valid` is raised, it stays high with `dn_addr` and `dn_write` stable until `dn_ready` is seen.
- R10: Address bits [3:0] are ignored. Two addresses that differ only there refer to the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every line; acted on when idle |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_write | input | 1 | 1 = line write, 0 = line read |
| up_addr | input | ADDR_W | Physical address of the line |
| up_wdata | input | LINE_W | Line data for writes |
| up_rvalid | output | 1 | One-cycle read response strobe |
| up_rdata | output | LINE_W | Read response line |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | 1 = downstream write, 0 = downstream read |
| dn_addr | output | ADDR_W | Line-aligned downstream address |
| dn_wdata | output | LINE_W | Downstream write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | LINE_W | Downstream read data |

## Verification
A wrong tag, valid bit or round-robin pointer shows up on the downstream port. On the next read of the affected line, a downstream read appears where none should, or is missing where one should appear. Bad data in the store shows up on `up_rdata` at the two-cycle hit response. Because writes go through, the correct value always equals what the bench's downstream memory holds. The bench models set contents and pointers with plain arrays. It also runs conflict sequences of five lines in one set, so that a misplaced victim turns into a hit/miss mismatch within a few requests.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_LINE_BYTES = 16;
    localparam int unsigned DEF_SETS       = 64;
    localparam int unsigned DEF_WAYS       = 4;

    typedef enum logic [2:0] {
        ST_CLR,
        ST_IDLE,
        ST_LOOK,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ
    } vc_state_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vc_victim_sel.sv
module vc_victim_sel #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim
);
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = rr_ptr;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vc_tag_store.sv
module vc_tag_store #(
    parameter int unsigned SETS  = 64,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 22,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned WAY_W = 2
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             upd_alloc,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAY_W-1:0] ptr_q   [SETS];
    logic [WAYS-1:0]  match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    vc_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid  (valid_q[lk_idx]),
        .rr_ptr (ptr_q[lk_idx]),
        .victim (victim_way)
    );

    always_ff @(posedge clk) begin
        if (clr_en) begin
            valid_q[clr_idx] <= '0;
            ptr_q[clr_idx]   <= '0;
        end else if (upd_en) begin
            valid_q[lk_idx][upd_way] <= 1'b1;
            tag_q[lk_idx][upd_way]   <= lk_tag;
            if (upd_alloc) begin
                ptr_q[lk_idx] <= (ptr_q[lk_idx] == LAST_WAY) ? '0 : ptr_q[lk_idx] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vc_data_store.sv
module vc_data_store #(
    parameter int unsigned SETS   = 64,
    parameter int unsigned WAYS   = 4,
    parameter int unsigned LINE_W = 128,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned WAY_W  = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [LINE_W-1:0] rd_data
);
    logic [LINE_W-1:0] line_q [SETS][WAYS];

    assign rd_data = line_q[idx][rd_way];

    always_ff @(posedge clk) begin
        if (wr_en) line_q[idx][wr_way] <= wr_data;
    end
endmodule

// File: rtl/line_cache_mid.sv
module line_cache_mid
    import vc_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned SETS       = DEF_SETS,
    parameter int unsigned WAYS       = DEF_WAYS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    up_valid,
    output logic                    up_ready,
    input  logic                    up_write,
    input  logic [ADDR_W-1:0]       up_addr,
    input  logic [LINE_BYTES*8-1:0] up_wdata,
    output logic                    up_rvalid,
    output logic [LINE_BYTES*8-1:0] up_rdata,
    output logic                    dn_valid,
    input  logic                    dn_ready,
    output logic                    dn_write,
    output logic [ADDR_W-1:0]       dn_addr,
    output logic [LINE_BYTES*8-1:0] dn_wdata,
    input  logic                    dn_rvalid,
    input  logic [LINE_BYTES*8-1:0] dn_rdata
);
    localparam int unsigned OFF_W  = width_of(LINE_BYTES);
    localparam int unsigned IDX_W  = width_of(SETS);
    localparam int unsigned WAY_W  = width_of(WAYS);
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned LINE_W = LINE_BYTES * 8;
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    typedef struct packed {
        logic              write;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [LINE_W-1:0] data;
    } req_t;

    vc_state_e         state_q, state_d;
    req_t              req_q;
    logic [IDX_W-1:0]  clr_q;
    logic              rsp_v_q;
    logic [LINE_W-1:0] rsp_d_q;

    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim_way, upd_way;
    logic              upd_en, upd_from_dn, clr_en;
    logic [LINE_W-1:0] upd_data, rd_data;
    logic              accept;

    assign up_ready  = (state_q == ST_IDLE) && !flush;
    assign accept    = up_ready && up_valid;
    assign up_rvalid = rsp_v_q;
    assign up_rdata  = rsp_d_q;

    assign dn_valid  = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    assign dn_write  = (state_q == ST_WR_REQ);
    assign dn_addr   = {req_q.tag, req_q.idx, {OFF_W{1'b0}}};
    assign dn_wdata  = req_q.data;

    assign upd_way   = hit ? hit_way : victim_way;
    assign upd_data  = upd_from_dn ? dn_rdata : req_q.data;

    vc_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk        (clk),
        .lk_idx     (req_q.idx),
        .lk_tag     (req_q.tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .upd_en     (upd_en),
        .upd_way    (upd_way),
        .upd_alloc  (!hit),
        .clr_en     (clr_en),
        .clr_idx    (clr_q)
    );

    vc_data_store #(
        .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (upd_en),
        .idx     (req_q.idx),
        .wr_way  (upd_way),
        .wr_data (upd_data),
        .rd_way  (hit_way),
        .rd_data (rd_data)
    );

    always_comb begin
        state_d     = state_q;
        clr_en      = 1'b0;
        upd_en      = 1'b0;
        upd_from_dn = 1'b0;
        unique case (state_q)
            ST_CLR: begin
                clr_en = 1'b1;
                if (clr_q == LAST_SET) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (flush)         state_d = ST_CLR;
                else if (up_valid) state_d = ST_LOOK;
            end
            ST_LOOK: begin
                if (req_q.write) begin
                    upd_en  = 1'b1;
                    state_d = ST_WR_REQ;
                end else if (hit) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_RD_REQ;
                end
            end
            ST_RD_REQ: if (dn_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (dn_rvalid) begin
                    upd_en      = 1'b1;
                    upd_from_dn = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            ST_WR_REQ: if (dn_ready) state_d = ST_IDLE;
            default: state_d = ST_CLR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLR;
            clr_q   <= '0;
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            state_q <= state_d;
            rsp_v_q <= 1'b0;
            if (clr_en) clr_q <= (clr_q == LAST_SET) ? '0 : clr_q + 1'b1;
            if (state_q == ST_LOOK && !req_q.write && hit) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= rd_data;
            end
            if (state_q == ST_RD_WAIT && dn_rvalid) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= dn_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            req_q.write <= up_write;
            req_q.tag   <= up_addr[ADDR_W-1:IDX_W+OFF_W];
            req_q.idx   <= up_addr[IDX_W+OFF_W-1:OFF_W];
            req_q.data  <= up_wdata;
        end
    end
endmodule

// File: rtl/vc_mid_checker.sv
module vc_mid_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_ready,
    input logic              up_rvalid,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic              dn_write,
    input logic [ADDR_W-1:0] dn_addr
);
    localparam int unsigned OFF_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;

    // R9
    dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write));

    // R8
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> !up_ready);

    // R8
    one_out_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready |=> !up_ready);

    // R3
    dn_align_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> dn_addr[OFF_W-1:0] == '0);

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        up_rvalid |=> !up_rvalid);
endmodule

bind line_cache_mid vc_mid_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/tb_line_cache_mid.sv
module tb_line_cache_mid;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 128;
    localparam int SETS = 64;
    localparam int WAYS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic up_valid = 1'b0, up_write = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [LINE_W-1:0] up_wdata = '0;
    logic up_ready, up_rvalid;
    logic [LINE_W-1:0] up_rdata;
    logic dn_valid, dn_write;
    logic [ADDR_W-1:0] dn_addr;
    logic [LINE_W-1:0] dn_wdata;
    logic dn_ready = 1'b0, dn_rvalid = 1'b0;
    logic [LINE_W-1:0] dn_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_cache_mid dut (.*);

    int n_vec = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference state
    bit ref_v   [SETS][WAYS];
    int ref_tag [SETS][WAYS];
    int ref_ptr [SETS];
    logic [LINE_W-1:0] mem [int];

    // downstream observation
    int dn_rd_cnt = 0, dn_wr_cnt = 0;
    logic [ADDR_W-1:0] last_dn_addr;
    logic [LINE_W-1:0] last_dn_wdata;
    int rvalid_cyc = 0;
    bit stall_en = 1'b0;

    function automatic logic [LINE_W-1:0] seed_line(input int line);
        logic [31:0] h;
        h = line * 32'h9E3779B1 ^ 32'h5A5A1234;
        return {h, ~h, h ^ 32'h0F0F0F0F, h + 32'd77};
    endfunction

    function automatic logic [LINE_W-1:0] mem_rd(input int line);
        return mem.exists(line) ? mem[line] : seed_line(line);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // downstream responder: decisions at negedge, effective at next posedge
    initial begin
        int lat;
        int pend_line;
        bit pend;
        pend = 1'b0; lat = 0; pend_line = 0;
        forever begin
            @(negedge clk);
            dn_rvalid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    dn_rvalid = 1'b1;
                    dn_rdata = mem_rd(pend_line);
                    rvalid_cyc = cyc;
                    pend = 1'b0;
                end else lat--;
            end
            dn_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
            if (dn_valid && dn_ready) begin
                last_dn_addr = dn_addr;
                if (dn_write) begin
                    dn_wr_cnt++;
                    last_dn_wdata = dn_wdata;
                    mem[int'(dn_addr >> 4)] = dn_wdata;
                end else begin
                    dn_rd_cnt++;
                    pend = 1'b1;
                    pend_line = int'(dn_addr >> 4);
                    lat = stall_en ? int'($urandom % 3) : 0;
                end
            end
        end
    end

    task automatic ref_clear();
        for (int s = 0; s < SETS; s++) begin
            ref_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                ref_v[s][w] = 1'b0;
                ref_tag[s][w] = 0;
            end
        end
    endtask

    function automatic int ref_find(input int s, input int t);
        for (int w = 0; w < WAYS; w++)
            if (ref_v[s][w] && ref_tag[s][w] == t) return w;
        return -1;
    endfunction

    task automatic ref_alloc(input int s, input int t);
        int w;
        w = -1;
        for (int k = 0; k < WAYS; k++)
            if (!ref_v[s][k] && w < 0) w = k;
        if (w < 0) w = ref_ptr[s];
        ref_v[s][w] = 1'b1;
        ref_tag[s][w] = t;
        ref_ptr[s] = (ref_ptr[s] + 1) % WAYS;
    endtask

    task automatic count_ready_low(input string req);
        int n;
        n = 0;
        while (!up_ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == SETS, req, LINE_W'(n), LINE_W'(SETS));
    endtask

    task automatic do_flush();
        while (!up_ready) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        ref_clear();
        count_ready_low("R1 flush ready-low cycles");
    endtask

    // one upstream request; hit/miss judged by downstream read traffic
    task automatic do_op(input bit wr, input logic [ADDR_W-1:0] addr,
                         input logic [LINE_W-1:0] data, input string tag_req);
        int line, s, t, rd0, wr0, lat, rsp_cyc;
        bit exp_hit, got;
        logic [LINE_W-1:0] got_d, exp_d;
        line = int'(addr >> 4);
        s = line % SETS;
        t = line / SETS;
        exp_hit = (ref_find(s, t) >= 0);
        while (!up_ready) @(negedge clk);
        rd0 = dn_rd_cnt; wr0 = dn_wr_cnt;
        up_valid = 1'b1; up_write = wr; up_addr = addr; up_wdata = data;
        @(negedge clk);
        up_valid = 1'b0;
        lat = 1; got = 1'b0; got_d = '0; rsp_cyc = 0;
        while (!(up_ready && (wr || got)) && lat < 500) begin
            if (up_ready) chk(1'b0, "R8 ready high while busy", 1, 0);
            @(negedge clk);
            lat++;
            if (!wr && up_rvalid) begin
                got = 1'b1; got_d = up_rdata; rsp_cyc = cyc;
            end
        end
        if (wr) begin
            chk(dn_wr_cnt - wr0 == 1, "R5 one downstream write", LINE_W'(dn_wr_cnt - wr0), 1);
            chk(dn_rd_cnt == rd0, "R5 no downstream read on write", LINE_W'(dn_rd_cnt - rd0), 0);
            chk(last_dn_wdata == data, "R5 write data through", last_dn_wdata, data);
            chk(last_dn_addr == {addr[31:4], 4'h0}, "R5 aligned write address",
                LINE_W'(last_dn_addr), LINE_W'({addr[31:4], 4'h0}));
            if (!exp_hit) ref_alloc(s, t);
        end else begin
            exp_d = mem_rd(line);
            chk(got, {tag_req, " response seen"}, LINE_W'(got), 1);
            chk((dn_rd_cnt == rd0) == exp_hit, {tag_req, " R7 hit/miss"},
                LINE_W'(dn_rd_cnt - rd0), LINE_W'(!exp_hit));
            chk(got_d == exp_d, {tag_req, " read data"}, got_d, exp_d);
            if (exp_hit) begin
                chk(lat == 2, "R2 hit latency", LINE_W'(lat), 2);
            end else begin
                chk(last_dn_addr == {addr[31:4], 4'h0}, "R3 aligned read address",
                    LINE_W'(last_dn_addr), LINE_W'({addr[31:4], 4'h0}));
                chk(rsp_cyc - rvalid_cyc == 1, "R3 response one cycle after fill",
                    LINE_W'(rsp_cyc - rvalid_cyc), 1);
                ref_alloc(s, t);
            end
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int off);
        return ADDR_W'((t << 10) | (s << 4) | (off & 15));
    endfunction

    initial begin
        ref_clear();
        repeat (3) @(negedge clk);
        chk(up_ready == 1'b0, "R1 ready low in reset", LINE_W'(up_ready), 0);
        chk(dn_valid == 1'b0 && up_rvalid == 1'b0, "R1 outputs idle in reset",
            LINE_W'({dn_valid, up_rvalid}), 0);
        rst = 1'b0;
        count_ready_low("R1 reset ready-low cycles");

        // R3 / R4 / R2: miss then hit
        do_op(0, mk(3, 5, 0), '0, "R3 miss");
        do_op(0, mk(3, 5, 0), '0, "R2 hit after fill R4");
        // R10: offset bits ignored
        do_op(0, mk(3, 5, 9), '0, "R10 offset ignored");
        // R5 / R6: write miss allocates, write hit updates
        do_op(1, mk(7, 9, 0), {4{32'hCAFE0001}}, "R5");
        do_op(0, mk(7, 9, 4), '0, "R6 read after write");
        do_op(1, mk(7, 9, 2), {4{32'hBEEF0002}}, "R5");
        do_op(0, mk(7, 9, 0), '0, "R6 in-place update");

        // R7: five lines in set 12; invalid ways first, then round robin
        for (int k = 0; k < 5; k++) do_op(0, mk(k + 1, 12, 0), '0, "R7 fill");
        do_op(0, mk(2, 12, 0), '0, "R7 survivor");
        do_op(0, mk(1, 12, 0), '0, "R7 evicted");
        do_op(1, mk(4, 12, 0), {4{32'h12345678}}, "R7");
        do_op(0, mk(3, 12, 0), '0, "R7 pointer after update");
        do_op(0, mk(6, 12, 0), '0, "R7 next victim");
        do_op(0, mk(4, 12, 0), '0, "R7 check");

        // R1: flush then previously held lines miss
        do_flush();
        do_op(0, mk(3, 5, 0), '0, "R1 miss after flush");
        do_op(0, mk(2, 12, 0), '0, "R1 miss after flush");

        // mixed traffic with downstream stalls
        stall_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            bit wr;
            int t, s;
            wr = ($urandom % 10) < 3;
            t = $urandom % 6;
            s = $urandom % 2;
            do_op(wr, mk(t, s, $urandom % 16), {$urandom, $urandom, $urandom, $urandom},
                  "R7 mixed");
            if (i == 200) do_flush();
        end
        stall_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule